// File: doc/BRIEF.md
# I2C serial EEPROM slave controller

This block is an I2C target that sits in front of a 1024-byte store. The store is modelled as a register array and keeps its contents for as long as the block is out of reset. The bus master reaches the device through eight consecutive slave-address codes. The two variable bits of the slave address supply the upper two bits of the 10-bit memory address. On a write, the byte that follows the slave address supplies the lower eight bits.

Writes carry one to sixteen data bytes. These bytes go into a one-page staging buffer and are committed to the store only when the master signals STOP. A programmable busy interval then models the self-timed erase/write cycle. During that interval the device leaves its own address unacknowledged. Reads return bytes from an internal pointer that runs through the whole array. They continue until the master declines a byte. A write-protect input blocks every commit.

SCL and SDA arrive as plain inputs and are oversampled by the system clock. The block drives SDA only through an active-high pull-down enable, as an open-drain pad expects.

Top module: `eeprom_i2c_slave`

## Requirements
- R1: The block acknowledges the first byte after a START only if its upper five bits are 1,0,1,0,1, whatever bits 2:1 and the R/W bit 0 hold. For any other first byte it gives no acknowledge and stays off the bus until the next START.
- R2: On a write (bit 0 = 0), the byte after the slave address is taken as address bits 7:0, and slave-address bits 2:1 become address bits 9:8. A write that ends after this word address leaves the pointer there for a following read.
- R3: A write of one data byte followed by STOP stores that byte at the addressed location, and the adjacent bytes are left unchanged.
- R4: Up to 16 data bytes per write are each acknowledged. After each byte only address bits 3:0 advance, and they wrap from 15 to 0 inside the same 16-byte page. Address bits 9:4 do not change.
- R5: If a write carries a 17th data byte, that byte and every later one go unacknowledged. The STOP then programs nothing and starts no busy interval.
- R6: Programming starts on STOP only. For BUSY_CYCLES clocks afterwards the block does not acknowledge its slave address.
- R7: If wp_i is high when STOP arrives, nothing is stored and no busy interval starts.
- R8: A read (bit 0 = 1) starts at address {slave-address bits 2:1, pointer bits 7:0}. The block sends that byte most significant bit first, then advances the full 10-bit pointer, wrapping from 3FFh to 000h. It keeps sending while the master acknowledges, and releases SDA after a master non-acknowledge.
- R9: After reset every byte of the store reads FFh and SDA is released.
- R10: The SDA pull-down enable changes only while SCL is low. An acknowledge is SDA held low through the ninth clock's high phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; also oversamples the bus lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| wp_i | input | 1 | Write protect, active high, sampled at STOP |
| sda_oe_o | output | 1 | Pull SDA low when high |

## Verification
Every one of the 256 first-byte values is offered after a START. A decoder that checked too few or too many address bits would acknowledge the wrong set of codes, or would fail to return erased data on an acknowledged read.

A page write starts in the middle of a page and is read back from the bytes on either side of it. A design that let the carry reach bit 4 would spill into the next page instead of wrapping.

A write of 17 and 18 data bytes checks the overflow rule. A design that committed partial data, or started its busy interval on that STOP, would show changed bytes or refuse its address at once.

Sequential reads across 3FFh, and a read whose slave-address bits differ from the stored pointer, expose a pointer that wraps per page or ignores the read-address bits. Writes under write protect and address probes right after a commit catch a busy interval that starts wrongly or not at all.

// File: rtl/eeprom_i2c_slave.sv
module eeprom_i2c_slave #(
  parameter int BUSY_CYCLES = 250000
)(
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic wp_i,
  output logic sda_oe_o
);
  localparam int AW    = 10;
  localparam int DEPTH = 1 << AW;
  localparam int PW    = 4;
  localparam int PAGE  = 1 << PW;
  localparam int CW    = $clog2(BUSY_CYCLES + 1);
  localparam logic [4:0] DEV_ID = 5'b10101;

  typedef enum logic [2:0] {S_IDLE, S_DEV, S_WADDR, S_WDATA, S_RD} state_t;

  state_t          st;
  logic [2:0]      scl_s, sda_s;
  logic [3:0]      bitcnt;
  logic [6:0]      sh;
  logic [7:0]      tx;
  logic [AW-1:0]   ptr;
  logic [PW:0]     wcnt;
  logic            ovf, ack_q, rw;
  logic [PAGE-1:0] mask;
  logic [7:0]      wbuf [PAGE];
  logic [7:0]      mem  [DEPTH];
  logic [CW-1:0]   busy_cnt;

  wire       scl_hi   = scl_s[1] & scl_s[2];
  wire       scl_rise = scl_s[1] & ~scl_s[2];
  wire       scl_fall = ~scl_s[1] & scl_s[2];
  wire       start_c  = scl_hi & sda_s[2] & ~sda_s[1];
  wire       stop_c   = scl_hi & ~sda_s[2] & sda_s[1];
  wire       sda_b    = sda_s[1];
  wire [7:0] rx       = {sh, sda_b};
  wire       busy     = busy_cnt != '0;
  wire [7:0] rd_byte  = mem[ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      scl_s    <= '1;
      sda_s    <= '1;
      bitcnt   <= '0;
      sh       <= '0;
      tx       <= '0;
      ptr      <= '0;
      wcnt     <= '0;
      ovf      <= 1'b0;
      ack_q    <= 1'b0;
      rw       <= 1'b0;
      mask     <= '0;
      busy_cnt <= '0;
      sda_oe_o <= 1'b0;
      for (int i = 0; i < PAGE; i++) wbuf[i] <= 8'hFF;
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else begin
      scl_s <= {scl_s[1:0], scl_i};
      sda_s <= {sda_s[1:0], sda_i};
      if (busy) busy_cnt <= busy_cnt - 1'b1;

      if (start_c) begin
        st       <= S_DEV;
        bitcnt   <= '0;
        sda_oe_o <= 1'b0;
        wcnt     <= '0;
        ovf      <= 1'b0;
        mask     <= '0;
      end else if (stop_c) begin
        if (st == S_WDATA && wcnt != '0 && !ovf && !wp_i && !busy) begin
          for (int i = 0; i < PAGE; i++)
            if (mask[i]) mem[{ptr[AW-1:PW], PW'(i)}] <= wbuf[i];
          busy_cnt <= CW'(BUSY_CYCLES);
        end
        st       <= S_IDLE;
        sda_oe_o <= 1'b0;
      end else if (st != S_IDLE) begin
        if (scl_rise) begin
          if (bitcnt < 4'd8) begin
            sh     <= rx[6:0];
            bitcnt <= bitcnt + 1'b1;
            if (bitcnt == 4'd7) begin
              case (st)
                S_DEV:
                  if (rx[7:3] == DEV_ID && !busy) begin
                    ack_q         <= 1'b1;
                    rw            <= rx[0];
                    ptr[AW-1:8]   <= rx[2:1];
                  end else begin
                    st <= S_IDLE;
                  end
                S_WADDR: begin
                  ack_q     <= 1'b1;
                  ptr[7:0]  <= rx;
                end
                S_WDATA:
                  if (wcnt == (PW+1)'(PAGE)) begin
                    ack_q <= 1'b0;
                    ovf   <= 1'b1;
                  end else begin
                    ack_q               <= 1'b1;
                    wbuf[ptr[PW-1:0]]   <= rx;
                    mask[ptr[PW-1:0]]   <= 1'b1;
                    ptr[PW-1:0]         <= ptr[PW-1:0] + 1'b1;
                    wcnt                <= wcnt + 1'b1;
                  end
                default: ;
              endcase
            end
          end else if (bitcnt == 4'd8) begin
            bitcnt <= 4'd9;
            if (st == S_RD && sda_b) st <= S_IDLE;
          end
        end else if (scl_fall) begin
          if (bitcnt == 4'd8) begin
            sda_oe_o <= (st != S_RD) & ack_q;
          end else if (bitcnt == 4'd9) begin
            bitcnt   <= '0;
            sda_oe_o <= 1'b0;
            if (st == S_WADDR) st <= S_WDATA;
            if (st == S_DEV && !rw) st <= S_WADDR;
            if (st == S_RD || (st == S_DEV && rw)) begin
              st       <= S_RD;
              tx       <= rd_byte;
              sda_oe_o <= ~rd_byte[7];
              ptr      <= ptr + 1'b1;
            end
          end else if (st == S_RD && bitcnt != '0) begin
            sda_oe_o <= ~tx[3'd7 - bitcnt[2:0]];
          end
        end
      end
    end
  end
endmodule

module eeprom_i2c_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] st,
  input logic       oe,
  input logic       scl_lvl,
  input logic       busy,
  input logic       stop_c,
  input logic       wp,
  input logic [4:0] wcnt
);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd0) |-> !oe);

  a_r10_oe_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(oe) |-> !scl_lvl);

  a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    wcnt <= 5'd16);

  a_r6_busy_from_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_c));

  a_r6_busy_no_session: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (st == 3'd0 || st == 3'd1));

  a_r7_wp_no_program: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_c && wp && !busy) |=> !busy);
endmodule

bind eeprom_i2c_slave eeprom_i2c_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .st(st), .oe(sda_oe_o), .scl_lvl(scl_s[1]),
  .busy(busy), .stop_c(stop_c), .wp(wp_i), .wcnt(wcnt)
);

// File: tb/test_eeprom_i2c_slave.sv
module test_eeprom_i2c_slave;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 5;
  localparam int BUSY = 400;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, m_low = 1'b0, wp = 1'b0;
  logic dut_oe;
  wire  sda = ~(m_low | dut_oe);
  int   checks = 0, failures = 0;
  logic [7:0] model [1024];
  logic [7:0] wv [20];
  logic       acks [20];

  eeprom_i2c_slave #(.BUSY_CYCLES(BUSY)) i_eeprom_i2c_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .wp_i(wp), .sda_oe_o(dut_oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic tick(input int n); repeat (n) @(negedge clk); endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_start;
    m_low = 1'b0; tick(Q); scl = 1'b1; tick(Q); m_low = 1'b1; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop;
    m_low = 1'b1; tick(Q); scl = 1'b1; tick(Q); m_low = 1'b0; tick(Q);
  endtask

  task automatic put_bit(input logic b);
    m_low = ~b; tick(Q); scl = 1'b1; tick(2*Q); scl = 1'b0; tick(Q);
  endtask

  task automatic get_bit(output logic b);
    m_low = 1'b0; tick(Q); scl = 1'b1; tick(Q); b = sda; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic put_byte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    ack = ~b;
  endtask

  task automatic get_byte(input logic more, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin get_bit(b); v[i] = b; end
    put_bit(~more);
  endtask

  task automatic read_check(input string tag, input logic [9:0] a, input int n);
    logic ack; logic [7:0] v;
    bus_start;
    put_byte({5'b10101, a[9:8], 1'b0}, ack); chk({tag, " R1 write address ack"}, ack, 1);
    put_byte(a[7:0], ack);                   chk({tag, " R2 word address ack"}, ack, 1);
    bus_start;
    put_byte({5'b10101, a[9:8], 1'b1}, ack); chk({tag, " R8 read address ack"}, ack, 1);
    for (int k = 0; k < n; k++) begin
      get_byte(k < n - 1, v);
      chk({tag, " data"}, v, model[10'(int'(a) + k)]);
    end
    bus_stop;
  endtask

  task automatic write_tx(input logic [9:0] a, input int n);
    logic ack;
    bus_start;
    put_byte({5'b10101, a[9:8], 1'b0}, ack); chk("R1 write address ack", ack, 1);
    put_byte(a[7:0], ack);                   chk("R2 word address ack", ack, 1);
    for (int k = 0; k < n; k++) put_byte(wv[k], acks[k]);
  endtask

  initial begin
    logic ack; logic [7:0] d;
    for (int i = 0; i < 1024; i++) model[i] = 8'hFF;
    tick(3); rst_n = 1'b1; tick(3);

    chk("R9 sda released after reset", dut_oe, 0);
    read_check("R9 erased bytes", 10'h000, 2);

    for (int v = 0; v < 256; v++) begin
      bus_start;
      put_byte(8'(v), ack);
      chk("R1 R10 slave address ack", ack, ((v >> 3) == 5'b10101) ? 1 : 0);
      if (ack && v[0]) begin
        get_byte(1'b0, d);
        chk("R8 R9 read after address", d, 8'hFF);
      end
      bus_stop;
    end

    wv[0] = 8'h5A;
    write_tx(10'h123, 1); chk("R3 data ack", acks[0], 1);
    bus_stop;
    bus_start; put_byte(8'hAA, ack); chk("R6 address refused while busy", ack, 0); bus_stop;
    model[10'h123] = 8'h5A;
    tick(BUSY);
    read_check("R3 byte write", 10'h122, 3);
    read_check("R8 pointer advance", 10'h122, 1);
    bus_start; put_byte(8'hAB, ack); chk("R8 current read ack", ack, 1);
    get_byte(1'b0, d); chk("R8 current address read", d, 8'h5A); bus_stop;

    for (int k = 0; k < 16; k++) wv[k] = 8'(k * 7 + 3);
    write_tx(10'h2A5, 16);
    for (int k = 0; k < 16; k++) chk("R4 page byte ack", acks[k], 1);
    bus_stop;
    for (int k = 0; k < 16; k++) model[10'h2A0 + ((5 + k) % 16)] = 8'(k * 7 + 3);
    tick(BUSY + 20);
    read_check("R4 page wrap", 10'h29F, 18);

    bus_start; put_byte(8'hA8, ack); put_byte(8'hA6, ack); bus_stop;
    bus_start; put_byte(8'hAD, ack); chk("R8 read address ack", ack, 1);
    get_byte(1'b1, d); chk("R8 upper bits from read address", d, model[10'h2A6]);
    get_byte(1'b0, d); chk("R8 sequential byte", d, model[10'h2A7]);
    bus_stop;

    wv[0] = 8'h77; wv[1] = 8'h88;
    write_tx(10'h3FE, 2); bus_stop;
    model[10'h3FE] = 8'h77; model[10'h3FF] = 8'h88;
    tick(BUSY + 20);
    wv[0] = 8'h99;
    write_tx(10'h000, 1); bus_stop;
    model[10'h000] = 8'h99;
    tick(BUSY + 20);
    read_check("R8 pointer wrap", 10'h3FE, 3);

    for (int k = 0; k < 18; k++) wv[k] = 8'(k + 8'h10);
    write_tx(10'h040, 18);
    for (int k = 0; k < 16; k++) chk("R5 first sixteen acked", acks[k], 1);
    chk("R5 17th byte refused", acks[16], 0);
    chk("R5 18th byte refused", acks[17], 0);
    bus_stop;
    bus_start; put_byte(8'hA8, ack); chk("R5 R6 no busy after overflow", ack, 1); bus_stop;
    read_check("R5 overflow discarded", 10'h040, 16);

    wp = 1'b1;
    wv[0] = 8'h11; wv[1] = 8'h22;
    write_tx(10'h300, 2);
    chk("R7 data ack under protect", acks[0], 1);
    bus_stop;
    tick(2); wp = 1'b0;
    bus_start; put_byte(8'hAE, ack); chk("R7 no busy under protect", ack, 1); bus_stop;
    read_check("R7 protected bytes", 10'h300, 2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog: run did not complete");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule